// File: doc/BRIEF.md
# Two-Phase Fork/Join Pipeline Stage

This block is the glue stage that lets transition-signaled pipeline stages form a non-linear pipeline. Two producer stages each offer a data word with a two-phase request. A completion gate of the Muller type waits until both requests have toggled to the same phase. The merged stage then captures the two words side by side and answers both producers with one shared acknowledge. The captured word and a single request phase go out to several consumer stages. A second completion gate folds all consumer acknowledges into one, and the stage takes no new item until every consumer has answered.

Every handshake is two-phase: each toggle of a request wire announces one new item, and each toggle of an acknowledge wire retires it. The stage is empty when its request phase equals the merged acknowledge phase, and it holds an item otherwise. Data travels bundled with its request. A producer keeps its word stable from its request toggle until it sees the acknowledge toggle.

Top module: `phase2_forkjoin`

## Requirements
- R1: After reset every request, acknowledge and completion state is 0, and the output word is 0.
- R2: A completion gate changes its output only when all of its inputs are equal, and then takes that common value. If one source request toggles and then toggles back before the other source moves, no item is produced.
- R3: The joined request toggles only after both source requests have toggled. If only one source has toggled, no request reaches the consumers and neither producer is acknowledged.
- R4: The output word is the concatenation of both source words, with the first source's word in the upper bits and the second source's word in the lower bits.
- R5: Both producers receive the same acknowledge phase, and it toggles in the same cycle the item is captured.
- R6: Every consumer receives the same request phase and the same data word.
- R7: While any consumer has not yet toggled its acknowledge for the held item, the stage captures nothing new, even if both sources offer a new item.
- R8: With the stage empty, the request to the consumers toggles on the second rising clock edge after the last source request toggles (one edge in the completion gate, one in the stage).
- R9: Under independent random delays on both sources and on every consumer, the n-th output word pairs the n-th item of the first source with the n-th item of the second, and no item is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| reqA | input | 1 | Two-phase request of the first producer |
| dataA | input | WIDTH_A | Data word of the first producer |
| ackA | output | 1 | Two-phase acknowledge to the first producer |
| reqB | input | 1 | Two-phase request of the second producer |
| dataB | input | WIDTH_B | Data word of the second producer |
| ackB | output | 1 | Two-phase acknowledge to the second producer |
| reqDst | output | NUM_DST | Two-phase request to each consumer |
| ackDst | input | NUM_DST | Two-phase acknowledge from each consumer |
| dataDst | output | WIDTH_A+WIDTH_B | Joined data word shared by all consumers |

## Verification
The bench builds the block with three consumers and 8-bit source words. Three consumers exercise the fork completion gate beyond the two-input case, so a design that merges only a pair of acknowledges, or treats two of three as enough, fails the hold test. Distinct 8-bit halves show at once whether the halves are swapped or misaligned in the joined word. The random-stream test lets each source and each consumer run ahead of the others by several items. Index pairing is then checked under real skew, not only in lockstep.

// File: rtl/phase2_fj_pkg.sv
package phase2_fj_pkg;

  // Strobes the control issues to the datapath each cycle.
  typedef struct packed {
    logic load;    // capture both source words this cycle
  } fjStrobe_t;

endpackage

// File: rtl/phase2_fj_celem.sv
module phase2_fj_celem #(
  parameter int NUM_IN = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] inVec,
  output logic              outPhase
);

  logic allHigh;
  logic allLow;

  assign allHigh = &inVec;
  assign allLow  = ~|inVec;

  // Completion state: follows the inputs only when they agree.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outPhase <= 1'b0;
    end else if (allHigh) begin
      outPhase <= 1'b1;
    end else if (allLow) begin
      outPhase <= 1'b0;
    end
  end

  p_hold_split_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((|inVec) && !(&inVec)) |=> $stable(outPhase));

  p_follow_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    (&inVec) |=> outPhase);

  p_follow_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    (~|inVec) |=> !outPhase);

endmodule

// File: rtl/phase2_fj_ctrl.sv
module phase2_fj_ctrl
  import phase2_fj_pkg::*;
#(
  parameter int NUM_DST = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqA,
  input  logic               reqB,
  input  logic [NUM_DST-1:0] ackDst,
  output logic               donePhase,
  output fjStrobe_t          strobe
);

  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0] srcReqs;
  logic               reqJoin;
  logic               ackMerged;
  logic               stageEmpty;
  logic               newItem;

  assign srcReqs = {reqA, reqB};

  // Join: one request once both producers have toggled.
  phase2_fj_celem #(.NUM_IN(NUM_SRC)) u_joinGate (
    .clk      (clk),
    .rstN     (rstN),
    .inVec    (srcReqs),
    .outPhase (reqJoin)
  );

  // Fork: one acknowledge once every consumer has toggled.
  phase2_fj_celem #(.NUM_IN(NUM_DST)) u_forkGate (
    .clk      (clk),
    .rstN     (rstN),
    .inVec    (ackDst),
    .outPhase (ackMerged)
  );

  // Stage latch enable: open while done and downstream ack agree.
  assign stageEmpty  = ~(donePhase ^ ackMerged);
  assign newItem     = reqJoin ^ donePhase;
  assign strobe.load = stageEmpty & newItem;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      donePhase <= 1'b0;
    end else if (strobe.load) begin
      donePhase <= reqJoin;
    end
  end

  p_wait_all_acks_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ackMerged != donePhase) |=> $stable(donePhase));

  p_wait_both_reqs_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqJoin == donePhase) |=> $stable(donePhase));

  p_done_tracks_join_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (donePhase == $past(reqJoin)));

endmodule

// File: rtl/phase2_fj_data.sv
module phase2_fj_data
  import phase2_fj_pkg::*;
#(
  parameter int WIDTH_A = 16,
  parameter int WIDTH_B = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  fjStrobe_t                  strobe,
  input  logic [WIDTH_A-1:0]         dataA,
  input  logic [WIDTH_B-1:0]         dataB,
  output logic [WIDTH_A+WIDTH_B-1:0] dataOut
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut <= '0;
    end else if (strobe.load) begin
      dataOut <= {dataA, dataB};
    end
  end

  p_word_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(dataOut));

  p_word_concat_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (dataOut == {$past(dataA), $past(dataB)}));

endmodule

// File: rtl/phase2_forkjoin.sv
module phase2_forkjoin
  import phase2_fj_pkg::*;
#(
  parameter int WIDTH_A = 16,
  parameter int WIDTH_B = 16,
  parameter int NUM_DST = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqA,
  input  logic [WIDTH_A-1:0]         dataA,
  output logic                       ackA,
  input  logic                       reqB,
  input  logic [WIDTH_B-1:0]         dataB,
  output logic                       ackB,
  output logic [NUM_DST-1:0]         reqDst,
  input  logic [NUM_DST-1:0]         ackDst,
  output logic [WIDTH_A+WIDTH_B-1:0] dataDst
);

  fjStrobe_t stageStrobe;
  logic      donePhase;

  phase2_fj_ctrl #(.NUM_DST(NUM_DST)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqA      (reqA),
    .reqB      (reqB),
    .ackDst    (ackDst),
    .donePhase (donePhase),
    .strobe    (stageStrobe)
  );

  phase2_fj_data #(.WIDTH_A(WIDTH_A), .WIDTH_B(WIDTH_B)) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (stageStrobe),
    .dataA   (dataA),
    .dataB   (dataB),
    .dataOut (dataDst)
  );

  // Done phase doubles as the acknowledge to both producers.
  assign ackA = donePhase;
  assign ackB = donePhase;

  // Same request phase to every consumer.
  for (genvar d = 0; d < NUM_DST; d++) begin : g_fork
    assign reqDst[d] = donePhase;
  end

  p_ack_moves_with_word_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ackA != $past(ackA)) |-> (dataDst == {$past(dataA), $past(dataB)}));

endmodule

// File: tb/phase2_forkjoin_bench.sv
module phase2_forkjoin_bench;

  localparam int WA = 8;
  localparam int WB = 8;
  localparam int ND = 3;
  localparam int NITEMS = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqA = 1'b0, reqB = 1'b0;
  logic [WA-1:0] dataA = '0;
  logic [WB-1:0] dataB = '0;
  logic ackA, ackB;
  logic [ND-1:0] reqDst;
  logic [ND-1:0] ackDst = '0;
  logic [WA+WB-1:0] dataDst;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  phase2_forkjoin #(.WIDTH_A(WA), .WIDTH_B(WB), .NUM_DST(ND)) u_phase2_forkjoin (
    .clk(clk), .rstN(rstN),
    .reqA(reqA), .dataA(dataA), .ackA(ackA),
    .reqB(reqB), .dataB(dataB), .ackB(ackB),
    .reqDst(reqDst), .ackDst(ackDst), .dataDst(dataDst)
  );

  function automatic logic [WA-1:0] itemA(int i);
    return WA'(i * 37 + 5);
  endfunction
  function automatic logic [WB-1:0] itemB(int i);
    return WB'(i * 91 + 3);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reqDst", 32'(reqDst), 0);
    chk("R1 ackA", 32'(ackA), 0);
    chk("R1 ackB", 32'(ackB), 0);
    chk("R1 data", 32'(dataDst), 0);
  endtask

  // Item 0: A first, B later; then latency check.
  task automatic t_join();
    dataA = 8'hA5; reqA = 1'b1;
    cyc(5);
    chk("R3 no req on one source", 32'(reqDst), 0);
    chk("R3 no ack on one source", 32'(ackA), 0);
    dataB = 8'h3C; reqB = 1'b1;
    cyc(1);
    chk("R8 not after one edge", 32'(reqDst), 0);
    cyc(1);
    chk("R8 req after two edges", 32'(reqDst), 32'(3'b111));
    chk("R4 concat", 32'(dataDst), 32'h0000A53C);
    chk("R5 ackA", 32'(ackA), 1);
    chk("R5 ackB", 32'(ackB), 1);
    chk("R6 all dst same", 32'(reqDst), 32'(3'b111));
  endtask

  // Item 1 held off while one consumer lags.
  task automatic t_forkHold();
    ackDst = 3'b011;
    dataA = 8'h11; dataB = 8'h22; reqA = 1'b0; reqB = 1'b0;
    cyc(6);
    chk("R7 req held", 32'(reqDst), 32'(3'b111));
    chk("R7 word held", 32'(dataDst), 32'h0000A53C);
    chk("R7 no ack", 32'(ackA), 1);
    ackDst = 3'b111;
    cyc(2);
    chk("R7 released req", 32'(reqDst), 0);
    chk("R7 released word", 32'(dataDst), 32'h00001122);
    ackDst = 3'b000;
    cyc(2);
  endtask

  // One source pulses away and back: gate must hold.
  task automatic t_glitch();
    reqA = 1'b1;
    cyc(3);
    reqA = 1'b0;
    cyc(5);
    chk("R2 no item on toggle-back", 32'(reqDst), 0);
    chk("R2 no ack on toggle-back", 32'(ackB), 0);
  endtask

  task automatic prodA();
    for (int i = 0; i < NITEMS; i++) begin
      cyc($urandom_range(0, 5));
      dataA = itemA(i); reqA = ~reqA;
      do @(negedge clk); while (ackA != reqA);
    end
  endtask

  task automatic prodB();
    for (int i = 0; i < NITEMS; i++) begin
      cyc($urandom_range(0, 5));
      dataB = itemB(i); reqB = ~reqB;
      do @(negedge clk); while (ackB != reqB);
    end
  endtask

  task automatic cons(int k);
    for (int i = 0; i < NITEMS; i++) begin
      do @(negedge clk); while (reqDst[k] == ackDst[k]);
      chk("R9 pairing", 32'(dataDst), 32'({itemA(i), itemB(i)}));
      cyc($urandom_range(0, 6));
      ackDst[k] = ~ackDst[k];
    end
  endtask

  task automatic t_stream();
    fork
      prodA();
      prodB();
      cons(0);
      cons(1);
      cons(2);
    join
    cyc(3);
    chk("R9 all retired", 32'(reqDst), 32'(ackDst));
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    t_reset();
    t_join();
    t_forkHold();
    t_glitch();
    t_stream();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule